// File: doc/BRIEF.md
# Serial ADC Frame Receiver

This receiver takes the single-line serial output of an eight-channel converter and turns it into parallel samples. It runs directly on the converter's bit clock. Because the converter changes its data line and its frame-start strobe on the rising edge, the receiver samples both on the falling edge. After each frame-start strobe it shifts in eight 24-bit frames, one per channel in ascending order. Each frame carries an 8-bit status header followed by a 16-bit two's-complement sample, both sent most significant bit first.

Each completed frame is split into its status header and its sample. A real sample is presented with a one-cycle valid pulse, its channel number and its filter flags. Placeholder frames, which the converter marks as repeated data, are dropped and only raise a drop pulse. The receiver keeps count of the slot it expects next and flags any frame whose channel number does not match that slot. A chip-error indication in any header is held in a sticky flag until the host clears it. A frame-start strobe that arrives partway through a frame discards the partial frame and starts again at channel 0.

Top module: `adc_frame_rx`

## Requirements
- R1: Data is sampled on the falling edge of `dclk_i`, and a frame is 24 consecutive bits, MSB first. Frame bits 23:16 form the header and bits 15:0 form the sample. A frame's outputs appear at the falling edge where its last bit is sampled and last exactly one clock cycle.
- R2: `smp_data_o` is the frame's bits 15:0, read as two's complement and sign-extended to `OUT_W` bits. `smp_chan_o` is the frame's bits 18:16, which hold the binary channel number.
- R3: The header flags are presented together with the sample. `flg_unsettled_o` is frame bit 22, `flg_sinc_o` is frame bit 20 (1 = sinc filter, 0 = wideband), and `flg_sat_o` is frame bit 19.
- R4: A frame whose bit 21 (repeated data) is set never raises `smp_valid_o`. It raises `rep_drop_o` for one cycle instead. Every other frame raises `smp_valid_o` and never raises `rep_drop_o`.
- R5: The k-th frame after a frame-start strobe (k = 0..7) is expected to carry channel k. `order_err_o` pulses with that frame's outputs when its channel field differs from k. This applies to repeated frames too.
- R6: When `drdy_i` is sampled high, the bit sampled in that cycle is the first bit of the channel-0 frame. Any partially received frame is discarded without producing outputs.
- R7: After the eighth frame of a group, further bits produce no output until `drdy_i` is sampled high again.
- R8: A completed frame with bit 23 (chip error) set makes `chip_err_o` go high one falling edge after that frame's outputs. It stays high until `chip_err_clr_i` is sampled high. If a chip-error frame completes in the same cycle as the clear, the set wins.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_i | input | 1 | Converter bit clock; all state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drdy_i | input | 1 | Frame-start strobe, high during the first bit of channel 0 |
| dout_i | input | 1 | Serial data line |
| chip_err_clr_i | input | 1 | Host clear for the sticky chip-error flag |
| smp_valid_o | output | 1 | One-cycle pulse for a real sample |
| smp_chan_o | output | 3 | Channel number from the header |
| smp_data_o | output | OUT_W | Sign-extended sample |
| flg_unsettled_o | output | 1 | Filter-not-settled flag |
| flg_sinc_o | output | 1 | Filter type flag, 1 = sinc |
| flg_sat_o | output | 1 | Filter saturation flag |
| rep_drop_o | output | 1 | Pulse when a repeated-data frame is dropped |
| order_err_o | output | 1 | Pulse when the channel field does not match the slot |
| chip_err_o | output | 1 | Sticky chip-error flag |

## Verification
The frame table mixes full-scale positive and negative samples, zero, -1 and alternating bit patterns, so that bit order, bit alignment and sign extension into a 20-bit output each show up as distinct wrong values. Every flag is set alone in some frames and combined with others in one frame, which separates a swapped flag from a missing one. Repeated frames sit both early and late in a group, and a swapped channel pair sits mid-group; together these tell dropping apart from order checking. Directed runs restart a group in the middle of a frame, send idle bits after a full group, and set, hold and clear the chip-error flag.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

   localparam int HDR_BITS = 8;
   localparam int ID_BITS  = 3;

   typedef struct packed {
      logic               chip_err;
      logic               unsettled;
      logic               repeated;
      logic               sinc;
      logic               saturated;
      logic [ID_BITS-1:0] chan;
   } hdr_t;

endpackage

// File: rtl/adc_rx_deframer.sv
module adc_rx_deframer #(
   parameter int FRAME_W = 24,
   parameter int NUM_CH  = 8,
   localparam int CNT_W  = $clog2(FRAME_W),
   localparam int POS_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               drdy_i,
   input  logic               din_i,
   output logic               frm_vld_o,
   output logic [FRAME_W-1:0] frm_word_o,
   output logic [POS_W-1:0]   frm_pos_o
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_CH - 1);

   if (FRAME_W < 3) begin : g_bad_frame
      $error("adc_rx_deframer: FRAME_W too small");
   end

   logic [FRAME_W-2:0] sh_q;
   logic [CNT_W-1:0]   bit_cnt_q;
   logic [POS_W-1:0]   pos_q;
   logic               active_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         bit_cnt_q  <= '0;
         pos_q      <= '0;
         active_q   <= 1'b0;
         frm_vld_o  <= 1'b0;
         frm_word_o <= '0;
         frm_pos_o  <= '0;
      end else if (drdy_i) begin
         sh_q      <= {{(FRAME_W-2){1'b0}}, din_i};
         bit_cnt_q <= CNT_W'(1);
         pos_q     <= '0;
         active_q  <= 1'b1;
         frm_vld_o <= 1'b0;
      end else if (active_q) begin
         if (bit_cnt_q == LAST_BIT) begin
            frm_vld_o  <= 1'b1;
            frm_word_o <= {sh_q, din_i};
            frm_pos_o  <= pos_q;
            bit_cnt_q  <= '0;
            if (pos_q == LAST_POS) begin
               pos_q    <= '0;
               active_q <= 1'b0;
            end else begin
               pos_q <= pos_q + POS_W'(1);
            end
         end else begin
            sh_q      <= {sh_q[FRAME_W-3:0], din_i};
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            frm_vld_o <= 1'b0;
         end
      end else begin
         frm_vld_o <= 1'b0;
      end
   end

   AST_ONE_FRAME_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
      frm_vld_o |=> !frm_vld_o); // R1
   AST_RESYNC_START: assert property (@(negedge clk) disable iff (!rst_n)
      drdy_i |=> (active_q && bit_cnt_q == CNT_W'(1) && pos_q == '0)); // R6
   AST_IDLE_NO_FRAME: assert property (@(negedge clk) disable iff (!rst_n)
      (!active_q && !drdy_i) |=> !frm_vld_o); // R7

endmodule

// File: rtl/adc_rx_unpack.sv
module adc_rx_unpack
   import adc_rx_pkg::*;
#(
   parameter int FRAME_W = 24,
   parameter int DATA_W  = 16,
   parameter int OUT_W   = 16
) (
   input  logic [FRAME_W-1:0] frame_i,
   output hdr_t               hdr_o,
   output logic [OUT_W-1:0]   sample_o
);

   if (FRAME_W != HDR_BITS + DATA_W) begin : g_bad_split
      $error("adc_rx_unpack: header plus data must fill the frame");
   end
   if (OUT_W < DATA_W) begin : g_bad_out
      $error("adc_rx_unpack: OUT_W must not be narrower than DATA_W");
   end

   logic [DATA_W-1:0] raw;

   assign hdr_o = hdr_t'(frame_i[FRAME_W-1 -: HDR_BITS]);
   assign raw   = frame_i[DATA_W-1:0];

   if (OUT_W > DATA_W) begin : g_sext
      assign sample_o = {{(OUT_W-DATA_W){raw[DATA_W-1]}}, raw};
   end else begin : g_plain
      assign sample_o = raw;
   end

endmodule

// File: rtl/adc_rx_status.sv
module adc_rx_status
   import adc_rx_pkg::*;
#(
   parameter int  POS_W  = 3,
   parameter bit  STICKY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_vld_i,
   input  hdr_t             hdr_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             clr_i,
   output logic             smp_valid_o,
   output logic             rep_drop_o,
   output logic             order_err_o,
   output logic             chip_err_o
);

   if (POS_W > ID_BITS) begin : g_bad_pos
      $error("adc_rx_status: more slots than the channel field can name");
   end

   logic [ID_BITS-1:0] exp_id;
   logic               chip_q;

   assign exp_id      = ID_BITS'(pos_i);
   assign smp_valid_o = frm_vld_i && !hdr_i.repeated;
   assign rep_drop_o  = frm_vld_i &&  hdr_i.repeated;
   assign order_err_o = frm_vld_i && (hdr_i.chan != exp_id);
   assign chip_err_o  = chip_q;

   if (STICKY) begin : g_sticky
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n)                              chip_q <= 1'b0;
         else if (frm_vld_i && hdr_i.chip_err)    chip_q <= 1'b1;
         else if (clr_i)                          chip_q <= 1'b0;
      end

      AST_STICKY_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
         (chip_q && !clr_i) |=> chip_q); // R8
      AST_CHIP_SET: assert property (@(negedge clk) disable iff (!rst_n)
         (frm_vld_i && hdr_i.chip_err) |=> chip_q); // R8
   end else begin : g_follow
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n)          chip_q <= 1'b0;
         else if (frm_vld_i)  chip_q <= hdr_i.chip_err;
      end
   end

   AST_DROP_EXCLUSIVE: assert property (@(negedge clk) disable iff (!rst_n)
      !(smp_valid_o && rep_drop_o)); // R4

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
   import adc_rx_pkg::*;
#(
   parameter int FRAME_W = 24,
   parameter int DATA_W  = 16,
   parameter int NUM_CH  = 8,
   parameter int OUT_W   = 16,
   parameter bit STICKY  = 1'b1,
   localparam int POS_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             dclk_i,
   input  logic             rst_ni,
   input  logic             drdy_i,
   input  logic             dout_i,
   input  logic             chip_err_clr_i,
   output logic             smp_valid_o,
   output logic [2:0]       smp_chan_o,
   output logic [OUT_W-1:0] smp_data_o,
   output logic             flg_unsettled_o,
   output logic             flg_sinc_o,
   output logic             flg_sat_o,
   output logic             rep_drop_o,
   output logic             order_err_o,
   output logic             chip_err_o
);

   logic               frm_vld;
   logic [FRAME_W-1:0] frm_word;
   logic [POS_W-1:0]   frm_pos;
   hdr_t               hdr;

   adc_rx_deframer #(.FRAME_W(FRAME_W), .NUM_CH(NUM_CH)) u_deframer (
      .clk        (dclk_i),
      .rst_n      (rst_ni),
      .drdy_i     (drdy_i),
      .din_i      (dout_i),
      .frm_vld_o  (frm_vld),
      .frm_word_o (frm_word),
      .frm_pos_o  (frm_pos)
   );

   adc_rx_unpack #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_unpack (
      .frame_i  (frm_word),
      .hdr_o    (hdr),
      .sample_o (smp_data_o)
   );

   adc_rx_status #(.POS_W(POS_W), .STICKY(STICKY)) u_status (
      .clk         (dclk_i),
      .rst_n       (rst_ni),
      .frm_vld_i   (frm_vld),
      .hdr_i       (hdr),
      .pos_i       (frm_pos),
      .clr_i       (chip_err_clr_i),
      .smp_valid_o (smp_valid_o),
      .rep_drop_o  (rep_drop_o),
      .order_err_o (order_err_o),
      .chip_err_o  (chip_err_o)
   );

   assign smp_chan_o      = hdr.chan;
   assign flg_unsettled_o = hdr.unsettled;
   assign flg_sinc_o      = hdr.sinc;
   assign flg_sat_o       = hdr.saturated;

endmodule

// File: tb/adc_frame_rx_bench.sv
`timescale 1ns/1ps
module adc_frame_rx_bench;

   localparam int OW = 20;

   logic dclk = 1'b0;
   logic rst_n = 1'b0;
   logic drdy = 1'b0;
   logic dout = 1'b0;
   logic clr  = 1'b0;
   logic          smp_valid, unsettled, sinc, sat, rep_drop, order_err, chip_err;
   logic [2:0]    chan;
   logic [OW-1:0] data;

   always #2.5 dclk = ~dclk;

   adc_frame_rx #(.OUT_W(OW)) u_adc_frame_rx (
      .dclk_i(dclk), .rst_ni(rst_n), .drdy_i(drdy), .dout_i(dout),
      .chip_err_clr_i(clr), .smp_valid_o(smp_valid), .smp_chan_o(chan),
      .smp_data_o(data), .flg_unsettled_o(unsettled), .flg_sinc_o(sinc),
      .flg_sat_o(sat), .rep_drop_o(rep_drop), .order_err_o(order_err),
      .chip_err_o(chip_err)
   );

   // header byte: [7] chip err, [6] unsettled, [5] repeated, [4] sinc, [3] saturated, [2:0] channel
   localparam logic [23:0] VEC [16] = '{
      24'h007FFF, 24'h118000, 24'h420000, 24'h230000,
      24'h0CFFFF, 24'h051234, 24'h360000, 24'h5FA5A5,
      24'h000001, 24'h01FFFE, 24'h024000, 24'h03C000,
      24'h050101, 24'h040202, 24'h863333, 24'h07FFFF };

   int n_tests = 0;
   int n_fail  = 0;
   int n_ev    = 0;
   logic          ev_val [64];
   logic          ev_rep [64];
   logic          ev_ord [64];
   logic [2:0]    ev_ch  [64];
   logic [OW-1:0] ev_dat [64];
   logic [2:0]    ev_flg [64];

   // outputs change on the falling edge; record them at the rising edge
   always @(posedge dclk) begin
      if ((smp_valid || rep_drop) && n_ev < 64) begin
         ev_val[n_ev] = smp_valid;
         ev_rep[n_ev] = rep_drop;
         ev_ord[n_ev] = order_err;
         ev_ch[n_ev]  = chan;
         ev_dat[n_ev] = data;
         ev_flg[n_ev] = {unsettled, sinc, sat};
         n_ev = n_ev + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic d, input logic rdy);
      @(posedge dclk); #1;
      drdy = rdy;
      dout = d;
   endtask

   task automatic send_group(input int base);
      for (int f = 0; f < 8; f++)
         for (int b = 23; b >= 0; b--)
            drive_bit(VEC[base+f][b], (f == 0 && b == 23));
   endtask

   task automatic idle(input int n, input logic d);
      for (int i = 0; i < n; i++) drive_bit(d, 1'b0);
   endtask

   task automatic cmp_frame(input int e, input logic [23:0] w, input int pos);
      logic [OW-1:0] exp_d;
      exp_d = {{(OW-16){w[15]}}, w[15:0]};
      chk(ev_val[e] == !w[21], "R4 valid", ev_val[e], !w[21]);
      chk(ev_rep[e] == w[21],  "R4 drop",  ev_rep[e], w[21]);
      chk(ev_ord[e] == (w[18:16] != 3'(pos)), "R5 order", ev_ord[e], (w[18:16] != 3'(pos)));
      if (!w[21]) begin
         chk(ev_ch[e] == w[18:16], "R2 channel", ev_ch[e], w[18:16]);
         chk(ev_dat[e] == exp_d, "R1 R2 data", ev_dat[e], exp_d);
         chk(ev_flg[e] == {w[22], w[20], w[19]}, "R3 flags", ev_flg[e], {w[22], w[20], w[19]});
      end
   endtask

   bit done = 1'b0;

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(posedge dclk);
      #1;
      // R9 reset state
      chk({smp_valid, rep_drop, order_err, chip_err} == 4'b0, "R9 flags", {smp_valid, rep_drop, order_err, chip_err}, 0);
      chk(data == '0 && chan == '0, "R9 data", data, 0);
      rst_n = 1'b1;
      idle(4, 1'b1);

      // table walk: two groups
      send_group(0);
      idle(3, 1'b0);
      chk(chip_err == 1'b0, "R8 no error yet", chip_err, 0);
      send_group(8);
      idle(3, 1'b0);
      chk(n_ev == 16, "R1 R4 event count", n_ev, 16);
      for (int i = 0; i < 16; i++) cmp_frame(i, VEC[i], i % 8);
      chk(chip_err == 1'b1, "R8 chip error set", chip_err, 1);

      // R7: bits after the eighth frame are ignored
      base = n_ev;
      idle(60, 1'b1);
      chk(n_ev == base, "R7 idle bits ignored", n_ev - base, 0);
      chk(chip_err == 1'b1, "R8 sticky hold", chip_err, 1);

      // R8 clear
      drive_bit(1'b0, 1'b0);
      clr = 1'b1;
      @(posedge dclk); #1;
      clr = 1'b0;
      chk(chip_err == 1'b0, "R8 cleared", chip_err, 0);

      // R6: restart in the middle of a frame
      base = n_ev;
      drive_bit(1'b1, 1'b1);
      for (int b = 0; b < 9; b++) drive_bit(b[0], 1'b0);
      send_group(0);
      idle(3, 1'b0);
      chk(n_ev - base == 8, "R6 restart event count", n_ev - base, 8);
      for (int i = 0; i < 8; i++) cmp_frame(base + i, VEC[i], i);
      chk(chip_err == 1'b0, "R8 stays clear", chip_err, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule